// File: doc/BRIEF.md
# Row/Column Thermometer Switch Controller for a Unary Current DAC

This block produces the switch controls for a 6-bit current-steering DAC in which every unit of output current comes from an identical cell. It takes a binary sample and turns on exactly as many unit cells as the sample's value. It never uses one flat decoder for this. The sample is split in two halves. The upper half feeds a row thermometer decoder and the lower half feeds a column thermometer decoder. A small gate at each cell combines the row code and the column code.

The cells form a grid of 8 rows by 8 columns, and the top-right corner position is left empty, which leaves 63 cells. Cell (r,c) has linear index r*8+c. A cell turns on when its row lies wholly below the active row. It also turns on when its row is the active row and the column code covers its column. All cell enables pass through one register on the sample clock, so every switch changes on the same edge. A synchronous active-high reset turns every cell off, which gives zero output current.

Top module: `udac_sw_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `cell_en` is 0 after that edge, whatever `code` is.
- R2: `cell_en` follows the `code` sampled at the previous rising edge. A new code has no effect on `cell_en` until the next edge, so the latency is exactly one cycle.
- R3: The number of asserted bits in `cell_en` equals the binary value of the registered code, for every code from 0 to 63.
- R4: The enables always form a prefix. Bit k of `cell_en` is 1 exactly when k is less than the registered code, so a lit cell always has every lower-indexed cell lit as well.
- R5: The row decoder takes `code[5:3]` and produces a 7-bit thermometer code whose bit i is 1 exactly when `code[5:3]` > i.
- R6: The column decoder takes `code[2:0]` and produces a 7-bit thermometer code whose bit j is 1 exactly when `code[2:0]` > j.
- R7: When two consecutive registered codes differ by one, exactly one bit of `cell_en` changes.
- R8: Cell index r*8+c is on exactly when r < `code[5:3]`, or when r equals `code[5:3]` and c < `code[2:0]`. The position r=7, c=7 holds no cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset, clears all enables |
| code | input | 6 | Binary sample: upper 3 bits select the row, lower 3 bits select the column |
| cell_en | output | 63 | Registered unit-cell enables, bit r*8+c drives cell (r,c) |

## Verification
The hardest case to reach from the ports is the set of row boundaries. At codes such as 7 to 8 or 55 to 56, the lower half wraps from 7 to 0 while the upper half steps up. A whole row then changes from partly on to fully on, and the column code collapses to zero at the same moment. The bench drives a complete upward ramp and a complete downward ramp of all 64 codes, one code per cycle. This crosses every row boundary in both directions and lets each single-step change be compared against the full expected enable vector. A separate burst that jumps between far-apart codes checks that the row and column halves stay consistent when both change at once.

// File: rtl/udac_pkg.sv
package udac_pkg;
  // Linear cell index of grid position (row, col) for a grid with 2**col_bits columns
  function automatic int cell_index(input int row, input int col, input int col_bits);
    return row * (1 << col_bits) + col;
  endfunction

  // Number of unit cells for a given code width (all codes except zero need a cell)
  function automatic int cell_count(input int code_bits);
    return (1 << code_bits) - 1;
  endfunction
endpackage

// File: rtl/udac_therm_dec.sv
module udac_therm_dec #(
  parameter int BW = 3,
  localparam int TW = (1 << BW) - 1
) (
  input  logic [BW-1:0] bin,
  output logic [TW-1:0] therm
);
  // Bit i is set when the binary input exceeds i
  for (genvar i = 0; i < TW; i++) begin : g_bit
    assign therm[i] = (int'(bin) > i);
  end

  // r5_ / r6_: the thermometer weight equals the binary value and has no gaps
  always_comb begin
    if (!$isunknown(bin)) begin
      p_therm_weight_r5_r6: assert ($countones(therm) == int'(bin) &&
                                    ((therm & (therm + 1'b1)) == '0))
        else $error("thermometer decoder mismatch for input %0d", bin);
    end
  end
endmodule

// File: rtl/udac_cell_matrix.sv
module udac_cell_matrix
  import udac_pkg::*;
#(
  parameter int HI_W = 3,
  parameter int LO_W = 3,
  localparam int ROWS  = 1 << HI_W,
  localparam int COLS  = 1 << LO_W,
  localparam int CELLS = ROWS * COLS - 1
) (
  input  logic [ROWS-2:0] row_th,
  input  logic [COLS-2:0] col_th,
  output logic [CELLS-1:0] en_d
);
  logic [ROWS-1:0] row_full;
  logic [ROWS-1:0] row_act;
  logic [COLS-1:0] col_ext;

  // The last column is never covered by the column code
  assign col_ext = {1'b0, col_th};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == ROWS - 1) begin : g_top
      assign row_full[r] = 1'b0;
    end else begin : g_mid
      assign row_full[r] = row_th[r];
    end
    if (r == 0) begin : g_first
      assign row_act[r] = ~row_full[r];
    end else begin : g_rest
      assign row_act[r] = row_th[r-1] & ~row_full[r];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = cell_index(r, c, LO_W);
      if (IDX < CELLS) begin : g_cell
        // Local gate at each cell: full row below, or partially filled active row
        assign en_d[IDX] = row_full[r] | (row_act[r] & col_ext[c]);
      end
    end
  end

  // r8_: exactly one row is the partially filled one
  always_comb begin
    if (!$isunknown(row_th)) begin
      p_one_active_row_r8: assert ($onehot0(row_act) && $countones(row_act) == 1)
        else $error("active row not unique");
    end
  end
endmodule

// File: rtl/udac_sw_ctrl.sv
module udac_sw_ctrl
  import udac_pkg::*;
#(
  parameter int HI_W = 3,
  parameter int LO_W = 3,
  localparam int CODE_W = HI_W + LO_W,
  localparam int ROWS   = 1 << HI_W,
  localparam int COLS   = 1 << LO_W,
  localparam int CELLS  = ROWS * COLS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [CELLS-1:0]  cell_en
);
  logic [ROWS-2:0]   row_th;
  logic [COLS-2:0]   col_th;
  logic [CELLS-1:0]  en_d;
  logic [CODE_W-1:0] sample_q;   // registered code, named for the assertions

  udac_therm_dec #(.BW(HI_W)) u_row_dec (
    .bin   (code[CODE_W-1:LO_W]),
    .therm (row_th)
  );

  udac_therm_dec #(.BW(LO_W)) u_col_dec (
    .bin   (code[LO_W-1:0]),
    .therm (col_th)
  );

  udac_cell_matrix #(.HI_W(HI_W), .LO_W(LO_W)) u_matrix (
    .row_th (row_th),
    .col_th (col_th),
    .en_d   (en_d)
  );

  // Synchronizing register: all switches move on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cell_en  <= '0;
      sample_q <= '0;
    end else begin
      cell_en  <= en_d;
      sample_q <= code;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (cell_en == '0))
    else $error("enables not cleared by reset");

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(cell_en) == int'($past(code))))
    else $error("enable count does not match code from previous edge");

  p_count_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(cell_en) == int'(sample_q))
    else $error("enable count differs from registered code");

  p_prefix_r4: assert property (@(posedge clk) disable iff (rst)
    (cell_en & (cell_en + 1'b1)) == '0)
    else $error("enables are not a prefix");

  p_single_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (sample_q == $past(sample_q) + 1'b1 ||
                     $past(sample_q) == sample_q + 1'b1))
      |-> ($countones(cell_en ^ $past(cell_en)) == 1))
    else $error("one-step code change toggled more than one cell");
endmodule

// File: tb/sim_udac_sw_ctrl.sv
module sim_udac_sw_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  code;
  logic [62:0] cell_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  udac_sw_ctrl u0 (.clk(clk), .rst(rst), .code(code), .cell_en(cell_en));

  always #5 clk = ~clk;

  // Reference: bit k is on when k is below the code value
  function automatic logic [62:0] expect_vec(input int v);
    logic [62:0] e;
    for (int k = 0; k < 63; k++) e[k] = (k < v);
    return e;
  endfunction

  function automatic int ones(input logic [62:0] v);
    int n = 0;
    for (int k = 0; k < 63; k++) n += int'(v[k]);
    return n;
  endfunction

  task automatic check(input string req, input logic [62:0] act, input logic [62:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample at the following negedge (one register in path)
  task automatic apply(input int v);
    code = 6'(v);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; code = 6'd63;
    @(negedge clk); @(negedge clk);
    check("R1 reset with full-scale code", cell_en, '0);
    rst = 1'b0;
  endtask

  task automatic t_ramp_up();
    logic [62:0] prev = cell_en;
    for (int v = 0; v < 64; v++) begin
      apply(v);
      check("R3/R4/R8 ramp up", cell_en, expect_vec(v));
      if (v > 0) check("R7 single toggle up", 63'(ones(cell_en ^ prev)), 63'd1);
      prev = cell_en;
    end
  endtask

  task automatic t_ramp_down();
    logic [62:0] prev = cell_en;
    for (int v = 62; v >= 0; v--) begin
      apply(v);
      check("R7 single toggle down", 63'(ones(cell_en ^ prev)), 63'd1);
      check("R3 ramp down count", 63'(ones(cell_en)), 63'(v));
      prev = cell_en;
    end
  endtask

  task automatic t_latency();
    apply(9);
    code = 6'd54;
    #1;
    check("R2 new code not visible before edge", cell_en, expect_vec(9));
    @(negedge clk);
    check("R2 new code visible after one edge", cell_en, expect_vec(54));
  endtask

  task automatic t_row_col_edges();
    // R5: whole rows only (lower half zero); R6: column extremes within a row
    int list[10] = '{8, 16, 56, 7, 15, 63, 1, 57, 32, 31};
    foreach (list[i]) begin
      apply(list[i]);
      check("R5/R6/R8 row and column boundaries", cell_en, expect_vec(list[i]));
    end
  endtask

  task automatic t_reset_mid();
    apply(40);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-stream", cell_en, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 resumes after reset", cell_en, expect_vec(40));
  endtask

  initial begin
    rst = 1'b1; code = '0;
    t_reset();
    t_ramp_up();
    t_ramp_down();
    t_latency();
    t_row_col_edges();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule